// File: doc/BRIEF.md
# Narrow Deblocking Edge Filter

This block smooths a block boundary in a video reconstruction loop by adjusting the two pixels on each side of the edge, named p1, p0 (before the edge) and q0, q1 (after it). Each lane takes four unsigned 8-bit pixels, a filter-enable bit and a high-variance bit. All of these come from an upstream decision stage. The lane returns four corrected pixels. A parameter sets the number of lanes, and each lane works on its own. A complete row or column of edge positions can therefore be processed in one pass.

Inside a lane the pixels are moved into a signed range by flipping their top bit. A correction value is built from the step across the edge using saturating arithmetic. The two inner pixels are pulled toward each other by two slightly different rounded steps. The outer pair gets a smaller correction, and only where the edge is smooth. An optional register stage with a valid flag lets the block sit inside a pipeline.

Top module: `narrow_edge_filter`

## Requirements
- R1: In any lane whose enable bit is 0, all four output pixels equal that lane's input pixels.
- R2: Each pixel u is handled as the signed value u−128 (top bit flipped) and is converted back the same way. The base term sat(p1−q1) takes part only when the lane's high-variance bit is 1; otherwise the base is 0.
- R3: The filter value f is the base plus sat(q0−p0), added three times in succession, with the sum clamped after each addition. f is forced to 0 when the enable bit is 0.
- R4: The new q0 is sat(q0 − t1), where t1 = sat(f+4) shifted right arithmetically by 3.
- R5: The new p0 is sat(p0 + t2), where t2 = sat(f+3) shifted right arithmetically by 3, so t1−t2 is always 0 or 1.
- R6: When the high-variance bit is 0, adj = (t1+1) shifted right arithmetically by 1, the new q1 is sat(q1 − adj) and the new p1 is sat(p1 + adj). When the bit is 1, p1 and q1 pass through unchanged.
- R7: Every signed intermediate and result clamps to [−128, 127]. For example, p1=p0=0, q0=q1=255 with enable=1 and variance=0 gives p1=8, p0=15, q0=240, q1=247.
- R8: With REG_OUT=1, results appear one clock after they are presented with in_valid=1, and out_valid is high in exactly that cycle. While in_valid is 0 the output pixels hold their last value. Reset clears out_valid and every output pixel to 0.
- R9: Lane i occupies bits [8i+7:8i] of every pixel bus and bit i of each flag bus. The result of a lane depends only on that lane's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixels and flags are valid this cycle |
| p1_i | input | 8*LANES | Outer pixel before the edge, per lane |
| p0_i | input | 8*LANES | Inner pixel before the edge, per lane |
| q0_i | input | 8*LANES | Inner pixel after the edge, per lane |
| q1_i | input | 8*LANES | Outer pixel after the edge, per lane |
| en_i | input | LANES | Per-lane filter enable |
| hv_i | input | LANES | Per-lane high-variance flag |
| out_valid | output | 1 | Output pixels are valid this cycle |
| p1_o | output | 8*LANES | Filtered outer pixel before the edge |
| p0_o | output | 8*LANES | Filtered inner pixel before the edge |
| q0_o | output | 8*LANES | Filtered inner pixel after the edge |
| q1_o | output | 8*LANES | Filtered outer pixel after the edge |

## Verification
The bench drives steps of full scale in both directions. A design that wraps instead of clamping, either in the three-fold accumulation or in the final add, turns a strong correction into one of the wrong sign and moves pixels across the whole range. Small negative filter values separate the +4 and +3 rounding of the inner pixels and the rounding of the outer adjustment. Swapping the offsets, using a logical shift or truncating the halving each leaves an off-by-one in p0, q0 or the outer pair. The bench also sets the enable and variance flags in every combination, including one enabled lane among disabled ones. A design that leaks between lanes, or that touches the outer pixels when variance is high, then produces visible changes where the pixels should pass through.

// File: rtl/nef_pkg.sv
package nef_pkg;

    localparam int PIX_W = 8;

    typedef logic        [PIX_W-1:0] upix_t;
    typedef logic signed [PIX_W-1:0] spix_t;
    typedef logic signed [PIX_W:0]   wide_t;

    localparam spix_t SMAX = {1'b0, {(PIX_W-1){1'b1}}};
    localparam spix_t SMIN = {1'b1, {(PIX_W-1){1'b0}}};
    localparam upix_t TOP_BIT = {1'b1, {(PIX_W-1){1'b0}}};

    typedef struct packed {
        upix_t p1;
        upix_t p0;
        upix_t q0;
        upix_t q1;
    } quad_t;

    function automatic wide_t widen(spix_t a);
        return {a[PIX_W-1], a};
    endfunction

    function automatic spix_t clamp(wide_t v);
        if (v > widen(SMAX)) return SMAX;
        if (v < widen(SMIN)) return SMIN;
        return v[PIX_W-1:0];
    endfunction

    function automatic spix_t sadd(spix_t a, spix_t b);
        return clamp(widen(a) + widen(b));
    endfunction

    function automatic spix_t ssub(spix_t a, spix_t b);
        return clamp(widen(a) - widen(b));
    endfunction

    function automatic spix_t to_signed(upix_t u);
        return spix_t'(u ^ TOP_BIT);
    endfunction

    function automatic upix_t to_unsigned(spix_t s);
        return upix_t'(s) ^ TOP_BIT;
    endfunction

endpackage

// File: rtl/nef_lane.sv
module nef_lane
    import nef_pkg::*;
(
    input  quad_t pix_i,
    input  logic  en_i,
    input  logic  hv_i,
    output quad_t pix_o
);

    spix_t sp1, sp0, sq0, sq1;
    spix_t base_d, step_d, acc1_d, acc2_d, acc3_d, filt_d;
    spix_t t1_d, t2_d, adj_d;
    wide_t adj_sum;

    always_comb begin
        sp1 = to_signed(pix_i.p1);
        sp0 = to_signed(pix_i.p0);
        sq0 = to_signed(pix_i.q0);
        sq1 = to_signed(pix_i.q1);

        base_d = hv_i ? ssub(sp1, sq1) : '0;
        step_d = ssub(sq0, sp0);
        acc1_d = sadd(base_d, step_d);
        acc2_d = sadd(acc1_d, step_d);
        acc3_d = sadd(acc2_d, step_d);
        filt_d = en_i ? acc3_d : '0;

        t1_d = sadd(filt_d, spix_t'(4)) >>> 3;
        t2_d = sadd(filt_d, spix_t'(3)) >>> 3;

        adj_sum = widen(t1_d) + wide_t'(1);
        adj_d   = hv_i ? '0 : adj_sum[PIX_W:1];

        pix_o.q0 = to_unsigned(ssub(sq0, t1_d));
        pix_o.p0 = to_unsigned(sadd(sp0, t2_d));
        pix_o.q1 = to_unsigned(ssub(sq1, adj_d));
        pix_o.p1 = to_unsigned(sadd(sp1, adj_d));
    end

    // R1: a disabled lane passes all pixels through
    always_comb begin
        if (!en_i)
            p_mask_pass_r1: assert (pix_o == pix_i)
                else $error("R1 disabled lane altered pixels");
    end

    // R5: the inner steps differ by the rounding offset only
    always_comb begin
        p_step_gap_r5: assert ((t1_d == t2_d) || (t1_d == t2_d + spix_t'(1)))
            else $error("R5 inner step gap out of range");
    end

    // R6: high variance leaves the outer pair untouched
    always_comb begin
        if (hv_i)
            p_outer_hold_r6: assert ((pix_o.p1 == pix_i.p1) && (pix_o.q1 == pix_i.q1))
                else $error("R6 outer pixel moved under high variance");
    end

endmodule

// File: rtl/nef_stage.sv
module nef_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) st_d.dat = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign data_o  = st_q.dat;

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o)
        else $error("R8 valid not delivered one cycle later");

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(data_o) && !valid_o))
        else $error("R8 outputs changed without a valid input");

endmodule

// File: rtl/narrow_edge_filter.sv
module narrow_edge_filter
    import nef_pkg::*;
#(
    parameter int LANES   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [PIX_W*LANES-1:0] p1_i,
    input  logic [PIX_W*LANES-1:0] p0_i,
    input  logic [PIX_W*LANES-1:0] q0_i,
    input  logic [PIX_W*LANES-1:0] q1_i,
    input  logic [LANES-1:0]       en_i,
    input  logic [LANES-1:0]       hv_i,
    output logic                   out_valid,
    output logic [PIX_W*LANES-1:0] p1_o,
    output logic [PIX_W*LANES-1:0] p0_o,
    output logic [PIX_W*LANES-1:0] q0_o,
    output logic [PIX_W*LANES-1:0] q1_o
);

    localparam int BUS_W  = PIX_W * LANES;
    localparam int DATA_W = 4 * BUS_W;

    logic [BUS_W-1:0]  np1, np0, nq0, nq1;
    logic [DATA_W-1:0] comb_data, out_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        quad_t lin, lout;
        assign lin.p1 = p1_i[g*PIX_W +: PIX_W];
        assign lin.p0 = p0_i[g*PIX_W +: PIX_W];
        assign lin.q0 = q0_i[g*PIX_W +: PIX_W];
        assign lin.q1 = q1_i[g*PIX_W +: PIX_W];

        nef_lane u_lane (
            .pix_i (lin),
            .en_i  (en_i[g]),
            .hv_i  (hv_i[g]),
            .pix_o (lout)
        );

        assign np1[g*PIX_W +: PIX_W] = lout.p1;
        assign np0[g*PIX_W +: PIX_W] = lout.p0;
        assign nq0[g*PIX_W +: PIX_W] = lout.q0;
        assign nq1[g*PIX_W +: PIX_W] = lout.q1;
    end

    assign comb_data = {nq1, nq0, np0, np1};

    if (REG_OUT) begin : g_reg
        nef_stage #(.DATA_W(DATA_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (in_valid),
            .data_i  (comb_data),
            .valid_o (out_valid),
            .data_o  (out_data)
        );

        for (genvar g = 0; g < LANES; g++) begin : g_chk
            // R1 / R9: disabled lane is passed through, whatever its neighbours do
            p_lane_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !en_i[g]) |=>
                    (p0_o[g*PIX_W +: PIX_W] == $past(p0_i[g*PIX_W +: PIX_W]) &&
                     q0_o[g*PIX_W +: PIX_W] == $past(q0_i[g*PIX_W +: PIX_W])))
                else $error("R9 disabled lane changed after register");
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = comb_data;
    end

    assign p1_o = out_data[0*BUS_W +: BUS_W];
    assign p0_o = out_data[1*BUS_W +: BUS_W];
    assign q0_o = out_data[2*BUS_W +: BUS_W];
    assign q1_o = out_data[3*BUS_W +: BUS_W];

endmodule

// File: tb/narrow_edge_filter_tb_top.sv
`timescale 1ns/1ps
module narrow_edge_filter_tb_top;

    localparam int LANES = 16;
    localparam int W     = 8 * LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] p1_i = '0, p0_i = '0, q0_i = '0, q1_i = '0;
    logic [LANES-1:0] en_i = '0, hv_i = '0;
    logic out_valid;
    logic [W-1:0] p1_o, p0_o, q0_o, q1_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    narrow_edge_filter #(.LANES(LANES), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .p1_i(p1_i), .p0_i(p0_i), .q0_i(q0_i), .q1_i(q1_i),
        .en_i(en_i), .hv_i(hv_i), .out_valid(out_valid),
        .p1_o(p1_o), .p0_o(p0_o), .q0_o(q0_o), .q1_o(q1_o)
    );

    typedef struct packed {
        logic [7:0] p1, p0, q0, q1;
        logic       en, hv;
        logic [7:0] e1, e0, f0, f1;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd100, 8'd100, 8'd100, 8'd100, 1'b1, 1'b0, 8'd100, 8'd100, 8'd100, 8'd100},
        '{8'd96,  8'd100, 8'd120, 8'd124, 1'b1, 1'b0, 8'd100, 8'd107, 8'd112, 8'd120},
        '{8'd96,  8'd100, 8'd120, 8'd124, 1'b1, 1'b1, 8'd96,  8'd104, 8'd116, 8'd124},
        '{8'd0,   8'd0,   8'd255, 8'd255, 1'b1, 1'b0, 8'd8,   8'd15,  8'd240, 8'd247},
        '{8'd255, 8'd255, 8'd0,   8'd0,   1'b1, 1'b0, 8'd247, 8'd239, 8'd16,  8'd8},
        '{8'd0,   8'd0,   8'd255, 8'd255, 1'b0, 1'b0, 8'd0,   8'd0,   8'd255, 8'd255},
        '{8'd0,   8'd0,   8'd255, 8'd255, 1'b1, 1'b1, 8'd0,   8'd15,  8'd240, 8'd255},
        '{8'd127, 8'd127, 8'd128, 8'd128, 1'b1, 1'b0, 8'd127, 8'd127, 8'd128, 8'd128},
        '{8'd130, 8'd130, 8'd128, 8'd128, 1'b1, 1'b0, 8'd130, 8'd129, 8'd129, 8'd128}
    };

    task automatic chk(input string req, input int lane, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual %0d expected %0d", req, lane, act, exp);
        end
    endtask

    function automatic int sc(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    // behavioural model built from R2..R7
    task automatic model(input int p1, input int p0, input int q0, input int q1,
                         input bit en, input bit hv,
                         output int o1, output int o0, output int r0, output int r1);
        int a1, a0, b0, b1, f, d, t1, t2, adj;
        a1 = p1 - 128; a0 = p0 - 128; b0 = q0 - 128; b1 = q1 - 128;
        f = hv ? sc(a1 - b1) : 0;
        d = sc(b0 - a0);
        f = sc(f + d); f = sc(f + d); f = sc(f + d);
        if (!en) f = 0;
        t1 = sc(f + 4) >>> 3;
        t2 = sc(f + 3) >>> 3;
        adj = hv ? 0 : ((t1 + 1) >>> 1);
        r0 = sc(b0 - t1) + 128;
        o0 = sc(a0 + t2) + 128;
        r1 = sc(b1 - adj) + 128;
        o1 = sc(a1 + adj) + 128;
    endtask

    function automatic int pick();
        case ($urandom % 5)
            0: return 0;
            1: return 127;
            2: return 128;
            3: return 255;
            default: return int'($urandom % 256);
        endcase
    endfunction

    task automatic present();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_lane(input string req, input int l,
                              input int e1, input int e0, input int f0, input int f1);
        chk(req, l, int'(p1_o[8*l +: 8]), e1);
        chk(req, l, int'(p0_o[8*l +: 8]), e0);
        chk(req, l, int'(q0_o[8*l +: 8]), f0);
        chk(req, l, int'(q1_o[8*l +: 8]), f1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset valid", 0, int'(out_valid), 0);
        chk("R8 reset data", 0, int'(p0_o[7:0]), 0);
        chk("R8 reset data", 0, int'(q1_o[W-8 +: 8]), 0);
        rst_n = 1'b1;

        // table walk, broadcast to every lane (R2..R7)
        for (int v = 0; v < NV; v++) begin
            for (int l = 0; l < LANES; l++) begin
                p1_i[8*l +: 8] = VECS[v].p1;
                p0_i[8*l +: 8] = VECS[v].p0;
                q0_i[8*l +: 8] = VECS[v].q0;
                q1_i[8*l +: 8] = VECS[v].q1;
                en_i[l] = VECS[v].en;
                hv_i[l] = VECS[v].hv;
            end
            present();
            chk("R8 valid", 0, int'(out_valid), 1);
            for (int l = 0; l < LANES; l++)
                check_lane("R4/R5/R6/R7 table", l, VECS[v].e1, VECS[v].e0, VECS[v].f0, VECS[v].f1);
        end

        // R8: hold while idle
        for (int l = 0; l < LANES; l++) begin
            p1_i[8*l +: 8] = 8'd3; p0_i[8*l +: 8] = 8'd200;
            q0_i[8*l +: 8] = 8'd9; q1_i[8*l +: 8] = 8'd250;
        end
        en_i = '1; hv_i = '0;
        @(negedge clk);
        chk("R8 idle valid", 0, int'(out_valid), 0);
        for (int l = 0; l < LANES; l++)
            check_lane("R8 hold", l, 130, 129, 129, 128);

        // R9: one enabled lane among disabled ones
        for (int l = 0; l < LANES; l++) begin
            p1_i[8*l +: 8] = 8'd96;  p0_i[8*l +: 8] = 8'd100;
            q0_i[8*l +: 8] = 8'd120; q1_i[8*l +: 8] = 8'd124;
        end
        en_i = '0; en_i[5] = 1'b1; hv_i = '0;
        present();
        for (int l = 0; l < LANES; l++) begin
            if (l == 5) check_lane("R9 enabled lane", l, 100, 107, 112, 120);
            else        check_lane("R1 disabled lane", l, 96, 100, 120, 124);
        end

        // random and boundary pixels, all flag combinations (R1..R7, R9)
        for (int it = 0; it < 400; it++) begin
            int e1 [LANES];
            int e0 [LANES];
            int f0 [LANES];
            int f1 [LANES];
            for (int l = 0; l < LANES; l++) begin
                int a, b, c, d;
                bit en, hv;
                a = pick(); b = pick(); c = pick(); d = pick();
                en = ((it + l) % 4) < 2;
                hv = ((it + l) % 2) == 1;
                p1_i[8*l +: 8] = 8'(a); p0_i[8*l +: 8] = 8'(b);
                q0_i[8*l +: 8] = 8'(c); q1_i[8*l +: 8] = 8'(d);
                en_i[l] = en; hv_i[l] = hv;
                model(a, b, c, d, en, hv, e1[l], e0[l], f0[l], f1[l]);
            end
            present();
            for (int l = 0; l < LANES; l++)
                check_lane("R2/R3/R9 random", l, e1[l], e0[l], f0[l], f1[l]);
        end

        // R8: reset clears a loaded output
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears valid", 0, int'(out_valid), 0);
        chk("R8 reset clears data", 0, int'(p1_o[7:0]), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule